// File: doc/BRIEF.md
# Acknowledge Polling Sequencer

This block is a master-side controller for a two-wire serial bus. It waits out the internal write cycle of a slave memory, which does not answer while it is busy. It sits above a bit-level bus engine that accepts four commands: start, stop, byte write and a completion report carrying the acknowledge status. A requester hands the sequencer one queued operation at a time. The operation is a read or a write, with a 7-bit device address and a byte address. The sequencer then probes the slave until it answers.

Each probe issues a start and then the device address with the direction bit at zero. A probe that gets no acknowledge is closed with a stop, and the next probe follows at once. When the slave acknowledges, the probe's address phase is reused. For a write, the byte address goes out straight away with no stop in between, and the requester carries on with the data. For a read, the probe is closed with a stop and the requester then runs its read transfer. A limit on the number of probes catches a slave that never answers.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout_err` and `cmd_valid` are all low.
- R2: A request is taken only while `busy` is low. A `req_valid` pulse while busy has no effect on the command stream, and `cmd_valid` stays low while the sequencer is idle.
- R3: Every probe is a start command (`cmd_op` = 0) followed by a write command (`cmd_op` = 2) whose `cmd_data` is {device address[6:0], 1'b0}. The device address sits in bits 7:1 and the direction bit in bit 0.
- R4: A probe that completes with `rsp_ack` low is followed by a stop command (`cmd_op` = 1) and then a new probe.
- R5: When a probe is acknowledged and the request is a write, the next command is a write of the byte address with no stop before it. Its completion ends the request with `done`.
- R6: When a probe is acknowledged and the request is a read, the next command is a stop. Its completion ends the request with `done`, and no byte address is sent.
- R7: If MAX_POLLS probes in a row go unacknowledged, the sequencer issues the stop after the last probe, then raises `timeout_err` and returns to idle without `done`. `timeout_err` stays high until the next request is accepted.
- R8: `cmd_valid`, `cmd_op` and `cmd_data` stay stable until `cmd_ready` is seen. No new command is presented until the engine has reported completion of the previous one on `rsp_valid`.
- R9: `done` is a single-cycle pulse, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, honoured when idle |
| req_write | input | 1 | 1 = next operation is a write, 0 = read |
| req_dev | input | 7 | Slave device address |
| req_baddr | input | 8 | Byte address sent for a write |
| busy | output | 1 | Sequencer is working on a request |
| done | output | 1 | One-cycle pulse: handoff to the next operation complete |
| timeout_err | output | 1 | Probe limit reached, held until the next request |
| cmd_valid | output | 1 | Command to bus engine is valid |
| cmd_ready | input | 1 | Bus engine accepts the command |
| cmd_op | output | 2 | 0 start, 1 stop, 2 byte write |
| cmd_data | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | Bus engine finished the accepted command |
| rsp_ack | input | 1 | Slave acknowledged the written byte |

## Verification
The hardest situation to reach from the ports is the timeout boundary. The slave has to stay silent for exactly the number of probes the limit allows, and each of those probes passes through a full command and completion handshake. The bench drives this with a bus-engine model. The model counts down a programmed number of refusals and answers only the write that follows a start. A refusal count above the limit forces the timeout, while smaller counts test the retry path just short of it. A later request then shows that the error flag clears.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2
  } ap_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START_C, S_START_W, S_ADDR_C, S_ADDR_W,
    S_STOP_C, S_STOP_W, S_BADDR_C, S_BADDR_W
  } ap_state_e;

  typedef enum logic [1:0] {
    WHY_RETRY, WHY_READ, WHY_TMO
  } ap_why_e;
endpackage

// File: rtl/ap_poll_ctr.sv
module ap_poll_ctr #(
  parameter int MAX_POLLS = 16,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CNT_W'(MAX_POLLS - 1));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MAX_POLLS));
endmodule

// File: rtl/ap_cmd_port.sv
module ap_cmd_port
  import ap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  ap_op_e            issue_op,
  input  logic [DATA_W-1:0] issue_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output ap_op_e            cmd_op,
  output logic [DATA_W-1:0] cmd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_START;
      cmd_data  <= '0;
    end else if (issue) begin
      cmd_valid <= 1'b1;
      cmd_op    <= issue_op;
      cmd_data  <= issue_data;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));
endmodule

// File: rtl/ap_fsm.sv
module ap_fsm
  import ap_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DEV_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DATA_W-1:0] req_baddr,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  input  logic              poll_last,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              issue,
  output ap_op_e            issue_op,
  output logic [DATA_W-1:0] issue_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  ap_state_e         state_q;
  ap_why_e           why_q;
  logic              wr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [DATA_W-1:0] baddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      why_q       <= WHY_RETRY;
      wr_q        <= 1'b0;
      dev_q       <= '0;
      baddr_q     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          wr_q        <= req_write;
          dev_q       <= req_dev;
          baddr_q     <= req_baddr;
          timeout_err <= 1'b0;
          state_q     <= S_START_C;
        end
        S_START_C: state_q <= S_START_W;
        S_START_W: if (rsp_valid) state_q <= S_ADDR_C;
        S_ADDR_C:  state_q <= S_ADDR_W;
        S_ADDR_W: if (rsp_valid) begin
          if (rsp_ack) begin
            if (wr_q) state_q <= S_BADDR_C;
            else begin
              why_q   <= WHY_READ;
              state_q <= S_STOP_C;
            end
          end else begin
            why_q   <= poll_last ? WHY_TMO : WHY_RETRY;
            state_q <= S_STOP_C;
          end
        end
        S_STOP_C: state_q <= S_STOP_W;
        S_STOP_W: if (rsp_valid) begin
          unique case (why_q)
            WHY_RETRY: state_q <= S_START_C;
            WHY_READ: begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end
            default: begin
              timeout_err <= 1'b1;
              state_q     <= S_IDLE;
            end
          endcase
        end
        S_BADDR_C: state_q <= S_BADDR_W;
        S_BADDR_W: if (rsp_valid) begin
          done    <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    issue      = 1'b0;
    issue_op   = OP_START;
    issue_data = '0;
    unique case (state_q)
      S_START_C: issue = 1'b1;
      S_ADDR_C: begin
        issue      = 1'b1;
        issue_op   = OP_WRITE;
        issue_data = {dev_q, 1'b0};
      end
      S_STOP_C: begin
        issue    = 1'b1;
        issue_op = OP_STOP;
      end
      S_BADDR_C: begin
        issue      = 1'b1;
        issue_op   = OP_WRITE;
        issue_data = baddr_q;
      end
      default: ;
    endcase
  end

  assign busy    = (state_q != S_IDLE);
  assign cnt_clr = (state_q == S_IDLE) && req_valid;
  assign cnt_inc = (state_q == S_ADDR_W) && rsp_valid && !rsp_ack;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  tmo_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> ($past(state_q) == S_STOP_W && !busy));
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
  import ap_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_POLLS = 16,
  localparam int DEV_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DATA_W-1:0] req_baddr,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack
);
  logic              cnt_clr, cnt_inc, poll_last, issue;
  ap_op_e            issue_op, port_op;
  logic [DATA_W-1:0] issue_data;

  ap_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_dev(req_dev), .req_baddr(req_baddr),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .poll_last(poll_last), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .issue(issue), .issue_op(issue_op), .issue_data(issue_data),
    .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  ap_poll_ctr #(.MAX_POLLS(MAX_POLLS)) ctr_i (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .last(poll_last)
  );

  ap_cmd_port #(.DATA_W(DATA_W)) port_i (
    .clk(clk), .rst(rst),
    .issue(issue), .issue_op(issue_op), .issue_data(issue_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(port_op), .cmd_data(cmd_data)
  );

  assign cmd_op = port_op;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !cmd_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/ack_poll_seq_tb_top.sv
module ack_poll_seq_tb_top;
  localparam int MAXP = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_dev = '0;
  logic [7:0] req_baddr = '0;
  logic       busy, done, timeout_err, cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       rsp_valid = 1'b0, rsp_ack = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0, nack_left = 0;
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  ack_poll_seq #(.DATA_W(8), .MAX_POLLS(MAXP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_dev(req_dev), .req_baddr(req_baddr), .busy(busy), .done(done),
    .timeout_err(timeout_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // Bus-engine model and scoreboard monitor
  initial begin : engine
    logic [1:0] prev_op = 2'd1;
    int k = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [9:0] got, want;
        bit probe;
        repeat (k % 3) @(negedge clk);
        k++;
        got = {cmd_op, cmd_data};
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected command", int'(got), 0);
        end else begin
          want = exp_q.pop_front();
          check(got == want, "R3/R4/R5/R6 command order", int'(got), int'(want));
        end
        probe = (prev_op == 2'd0) && (cmd_op == 2'd2);
        prev_op = cmd_op;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        repeat (2) begin
          @(negedge clk);
          if (cmd_valid) check(0, "R8 command before completion", 1, 0);
        end
        rsp_ack = probe ? (nack_left == 0) : 1'b1;
        if (probe && nack_left > 0) nack_left--;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_ack = 1'b0;
      end
    end
  end

  task automatic run_req(input bit wr, input logic [6:0] dev, input logic [7:0] ba,
                         input int nacks, input bit poke_busy);
    bit tmo = (nacks >= MAXP);
    int polls = tmo ? MAXP : nacks;
    int w = 0;
    nack_left = nacks;
    for (int i = 0; i < polls; i++) begin
      exp_q.push_back({2'd0, 8'h00});
      exp_q.push_back({2'd2, dev, 1'b0});
      exp_q.push_back({2'd1, 8'h00});
    end
    if (!tmo) begin
      exp_q.push_back({2'd0, 8'h00});
      exp_q.push_back({2'd2, dev, 1'b0});
      if (wr) exp_q.push_back({2'd2, ba});
      else    exp_q.push_back({2'd1, 8'h00});
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_baddr = ba;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_dev = ~dev; req_baddr = ~ba;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && !timeout_err && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (tmo) begin
      check(timeout_err == 1'b1, "R7 timeout flag", timeout_err, 1);
      check(done == 1'b0, "R7 no done on timeout", done, 0);
      check(busy == 1'b0, "R7 idle on timeout", busy, 0);
    end else begin
      check(done == 1'b1, wr ? "R5 done" : "R6 done", done, 1);
      check(busy == 1'b0, "R9 busy low with done", busy, 0);
      check(timeout_err == 1'b0, "R7 flag clear on new request", timeout_err, 0);
      @(negedge clk);
      check(done == 1'b0, "R9 done single cycle", done, 0);
    end
    repeat (12) begin
      @(negedge clk);
      if (cmd_valid) check(0, "R2 command while idle", 1, 0);
    end
    check(exp_q.size() == 0, "R3/R4 all expected commands seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !timeout_err && !cmd_valid, "R1 reset state",
          {busy, done, timeout_err, cmd_valid}, 0);
    rst = 1'b0;
    run_req(1'b1, 7'h50, 8'h3C, 0, 1'b0);  // R5 immediate ack
    run_req(1'b1, 7'h51, 8'h00, 3, 1'b1);  // R4/R5 retries, R2 poke
    run_req(1'b0, 7'h2A, 8'hFF, 2, 1'b0);  // R6 read after retries
    run_req(1'b0, 7'h7F, 8'h11, 0, 1'b1);  // R6 immediate
    run_req(1'b1, 7'h01, 8'h80, MAXP - 1, 1'b0); // R7 just below limit
    run_req(1'b1, 7'h33, 8'h44, MAXP + 5, 1'b0); // R7 timeout
    run_req(1'b0, 7'h33, 8'h44, 1, 1'b0);  // R7 flag cleared on next request
    finish_run();
  end
endmodule